// File: doc/BRIEF.md
# Dock Move Instruction Controller

This block sequences a single decoded move instruction at a dock. An upstream stage presents the move's decoded control fields together with `mv_valid` and holds them until the block pulses `retire`. The block first checks the predicate result and any pending torpedo. It then waits until the downstream data and token successors are both empty and, for moves that take an inbound packet, until a packet is present. When these conditions are met it fires. On firing it can ask the external loop counter to count down, take the inbound packet, latch a new C flag value from the packet's signal bit, and load the outgoing path register. The path comes either from the instruction immediate or from a field of the data-predecessor word.

A move with its repeat option set does not retire after firing. It passes through a one-cycle gap state and returns to the armed state, where the predicate is tested again before the next firing. Such a move runs until its predicate fails or a torpedo strikes. With the count option clear, a repeating move is a standing move that never asks for a count-down. A torpedo that is pending while a non-immune move waits kills that move: the move retires, the torpedo is consumed, and the loop counter is told to clear.

The controller has three states. ST_IDLE waits for a move. ST_ARMED evaluates and executes it. ST_GAP separates repeated firings. The transitions are named as follows:
- accept: ST_IDLE to ST_ARMED, taken when `mv_valid` is high.
- skip: ST_ARMED to ST_IDLE, taken when the predicate is false.
- strike: ST_ARMED to ST_IDLE, taken on a torpedo kill.
- finish: ST_ARMED to ST_IDLE, taken on a non-repeating firing.
- again: ST_ARMED to ST_GAP, taken on a repeating firing.
- rearm: ST_GAP to ST_ARMED, taken unconditionally.
- hold: ST_ARMED stays in ST_ARMED while the move waits.

Top module: `dock_move_ctrl`

## Requirements
- R1: `fire` is asserted only in a cycle in which `succ_empty` is high; while `succ_empty` is low, an armed move with a true predicate and no strike waits in ST_ARMED.
- R2: If `pred_ok` is low while the move is in ST_ARMED, `retire` pulses in that same cycle. In that case `fire`, `lc_dec`, `lc_clr` and `pkt_take` stay low, and neither `path_out` nor `c_flag` changes.
- R3: `fire` is never high in two consecutive cycles. After a firing with `mv_repeat`=1 the block spends one cycle in ST_GAP and then tests `pred_ok` again before any further firing.
- R4: `lc_dec` is high exactly in the cycles in which `fire` is high and `mv_count`=1. A standing move (`mv_repeat`=1, `mv_count`=0) never raises `lc_dec`.
- R5: If `torp_pend` is high, `mv_immune`=0 and `pred_ok`=1 while the move is in ST_ARMED, then `torp_take`, `lc_clr` and `retire` pulse together in that cycle and `fire` stays low. This holds even if the move could otherwise fire in that cycle.
- R6: With `mv_immune`=1, a pending torpedo has no effect: `torp_take` and `lc_clr` stay low and the move fires normally.
- R7: On a firing with `mv_tok_in` or `mv_data_in` set and `mv_keep_c`=0, `c_flag` takes `pkt_signal` on the next cycle; every other cycle leaves `c_flag` unchanged.
- R8: On a firing with `mv_path_mode`=2'b01, `path_out` takes `mv_imm` (13 bits) on the next cycle.
- R9: On a firing with `mv_path_mode`=2'b10, `path_out` takes `dpred_word[37:26]`, zero-extended to 13 bits, on the next cycle.
- R10: `mv_path_mode` values 2'b00 and 2'b11 leave `path_out` unchanged on a firing.
- R11: A move with `mv_tok_in` or `mv_data_in` set fires only when `pkt_valid` is high, and `pkt_take` is high exactly on such firings.
- R12: While `rst_n` is low and after reset, the block is in ST_IDLE. All strobes are low, `path_out` is 0 and `c_flag` is 0.
- R13: A move with `mv_repeat`=0 raises `retire` in the same cycle as its single `fire`. A move that arrives in ST_IDLE is accepted on the first clock, so it can fire no earlier than the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mv_valid | input | 1 | Decoded move present; held until `retire` |
| mv_repeat | input | 1 | Repeat option |
| mv_immune | input | 1 | Move cannot be killed by a torpedo |
| mv_count | input | 1 | Count down the loop counter on each firing |
| mv_tok_in | input | 1 | Move waits for an inbound token |
| mv_data_in | input | 1 | Move waits for an inbound data word |
| mv_keep_c | input | 1 | Leave the C flag untouched on firing |
| mv_path_mode | input | 2 | 01 immediate, 10 predecessor field, 00/11 keep path |
| mv_imm | input | 13 | Immediate path value |
| pred_ok | input | 1 | Predicate currently true |
| succ_empty | input | 1 | Data and token successors both empty |
| pkt_valid | input | 1 | Inbound packet present |
| pkt_signal | input | 1 | Signal bit of the inbound packet |
| dpred_word | input | 38 | Data-predecessor word |
| torp_pend | input | 1 | Torpedo waiting at the dock |
| fire | output | 1 | One-cycle execution strobe |
| pkt_take | output | 1 | Inbound packet consumed |
| lc_dec | output | 1 | Loop counter count-down request |
| lc_clr | output | 1 | Loop counter clear request |
| torp_take | output | 1 | Torpedo consumed |
| retire | output | 1 | Move finished; upstream may present the next one |
| path_out | output | 13 | Outgoing path register |
| c_flag | output | 1 | C flag register |

## Verification
The strobes `fire`, `pkt_take`, `lc_dec`, `lc_clr`, `torp_take` and `retire` are decided combinationally in ST_ARMED. They are due in the same cycle as the inputs that qualify them. `path_out` and `c_flag` are registers and change one clock after the firing. A newly presented move spends its first clock being accepted, and a repeating move spends one gap cycle between firings. The bench holds each input set from just after a falling edge. It advances its model state on the rising edge and compares every output at the following falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/dock_move_pkg.sv
package dock_move_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_GAP   = 2'd2
    } mv_state_t;

    typedef enum logic [1:0] {
        PM_KEEP = 2'b00,
        PM_IMM  = 2'b01,
        PM_DISP = 2'b10,
        PM_RSVD = 2'b11
    } path_mode_t;

endpackage

// File: rtl/dock_move_fsm.sv
module dock_move_fsm
    import dock_move_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mv_valid,
    input  logic mv_repeat,
    input  logic mv_immune,
    input  logic mv_count,
    input  logic mv_tok_in,
    input  logic mv_data_in,
    input  logic pred_ok,
    input  logic succ_empty,
    input  logic pkt_valid,
    input  logic torp_pend,
    output logic fire,
    output logic pkt_take,
    output logic lc_dec,
    output logic lc_clr,
    output logic torp_take,
    output logic retire
);

    mv_state_t state_q, state_d;
    logic      needs_pkt;
    logic      ready;
    logic      strike;

    assign needs_pkt = mv_tok_in | mv_data_in;
    assign ready     = succ_empty & (~needs_pkt | pkt_valid);
    assign strike    = torp_pend & ~mv_immune;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (mv_valid) state_d = ST_ARMED;               // accept
            ST_ARMED: begin
                if (!pred_ok)       state_d = ST_IDLE;                // skip
                else if (strike)    state_d = ST_IDLE;                // strike
                else if (ready)     state_d = mv_repeat ? ST_GAP      // again
                                                        : ST_IDLE;    // finish
            end
            ST_GAP:   state_d = ST_ARMED;                             // rearm
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fire      = 1'b0;
        pkt_take  = 1'b0;
        lc_dec    = 1'b0;
        lc_clr    = 1'b0;
        torp_take = 1'b0;
        retire    = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                if (!pred_ok) begin
                    retire = 1'b1;
                end else if (strike) begin
                    torp_take = 1'b1;
                    lc_clr    = 1'b1;
                    retire    = 1'b1;
                end else if (ready) begin
                    fire     = 1'b1;
                    pkt_take = needs_pkt;
                    lc_dec   = mv_count;
                    retire   = ~mv_repeat;
                end
            end
            ST_IDLE, ST_GAP: ;
            default: ;
        endcase
    end

    a_r1_succ_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> succ_empty);
    a_r2_pred_true: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> pred_ok);
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    a_r4_dec_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        lc_dec |-> (fire && mv_count));
    a_r5_strike_no_fire: assert property (@(posedge clk) disable iff (!rst_n)
        lc_clr |-> (torp_pend && !mv_immune && retire && !fire));
    a_r6_immune_safe: assert property (@(posedge clk) disable iff (!rst_n)
        torp_take |-> !mv_immune);
    a_r11_pkt_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (mv_tok_in || mv_data_in)) |-> pkt_valid);

endmodule

// File: rtl/dock_move_path.sv
module dock_move_path
    import dock_move_pkg::*;
#(
    parameter int PATH_W  = 13,
    parameter int DISP_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [1:0]        mode,
    input  logic [PATH_W-1:0] imm,
    input  logic [DISP_W-1:0] disp_field,
    output logic [PATH_W-1:0] path_q
);

    path_mode_t        mode_e;
    logic [PATH_W-1:0] disp_val;
    logic              load;
    logic [PATH_W-1:0] next_path;

    assign mode_e = path_mode_t'(mode);

    generate
        if (DISP_W >= PATH_W) begin : g_trunc
            assign disp_val = disp_field[PATH_W-1:0];
        end else begin : g_pad
            assign disp_val = {{(PATH_W-DISP_W){1'b0}}, disp_field};
        end
    endgenerate

    always_comb begin
        load      = 1'b0;
        next_path = path_q;
        unique case (mode_e)
            PM_IMM:  begin load = fire; next_path = imm;      end
            PM_DISP: begin load = fire; next_path = disp_val; end
            PM_KEEP, PM_RSVD: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    path_q <= '0;
        else if (load) path_q <= next_path;
    end

    a_r8_imm_load: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode == 2'b01) |=> (path_q == $past(imm)));
    a_r10_path_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && (mode == 2'b01 || mode == 2'b10)) |=> $stable(path_q));

endmodule

// File: rtl/dock_move_cflag.sv
module dock_move_cflag (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_take,
    input  logic keep_c,
    input  logic pkt_signal,
    output logic c_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)                 c_q <= 1'b0;
        else if (pkt_take && !keep_c) c_q <= pkt_signal;
    end

    a_r7_c_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_take && !keep_c) |=> $stable(c_q));

endmodule

// File: rtl/dock_move_ctrl.sv
module dock_move_ctrl #(
    parameter int PATH_W  = 13,
    parameter int WORD_W  = 38,
    parameter int DISP_HI = 37,
    parameter int DISP_LO = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mv_valid,
    input  logic              mv_repeat,
    input  logic              mv_immune,
    input  logic              mv_count,
    input  logic              mv_tok_in,
    input  logic              mv_data_in,
    input  logic              mv_keep_c,
    input  logic [1:0]        mv_path_mode,
    input  logic [PATH_W-1:0] mv_imm,
    input  logic              pred_ok,
    input  logic              succ_empty,
    input  logic              pkt_valid,
    input  logic              pkt_signal,
    input  logic [WORD_W-1:0] dpred_word,
    input  logic              torp_pend,
    output logic              fire,
    output logic              pkt_take,
    output logic              lc_dec,
    output logic              lc_clr,
    output logic              torp_take,
    output logic              retire,
    output logic [PATH_W-1:0] path_out,
    output logic              c_flag
);

    localparam int DISP_W = DISP_HI - DISP_LO + 1;

    generate
        if (DISP_LO > 0) begin : g_low
            logic low_unused;
            assign low_unused = ^dpred_word[DISP_LO-1:0];
        end
        if (DISP_HI < WORD_W - 1) begin : g_high
            logic high_unused;
            assign high_unused = ^dpred_word[WORD_W-1:DISP_HI+1];
        end
    endgenerate

    dock_move_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mv_valid   (mv_valid),
        .mv_repeat  (mv_repeat),
        .mv_immune  (mv_immune),
        .mv_count   (mv_count),
        .mv_tok_in  (mv_tok_in),
        .mv_data_in (mv_data_in),
        .pred_ok    (pred_ok),
        .succ_empty (succ_empty),
        .pkt_valid  (pkt_valid),
        .torp_pend  (torp_pend),
        .fire       (fire),
        .pkt_take   (pkt_take),
        .lc_dec     (lc_dec),
        .lc_clr     (lc_clr),
        .torp_take  (torp_take),
        .retire     (retire)
    );

    dock_move_path #(
        .PATH_W (PATH_W),
        .DISP_W (DISP_W)
    ) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .mode       (mv_path_mode),
        .imm        (mv_imm),
        .disp_field (dpred_word[DISP_HI:DISP_LO]),
        .path_q     (path_out)
    );

    dock_move_cflag u_cflag (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_take   (pkt_take),
        .keep_c     (mv_keep_c),
        .pkt_signal (pkt_signal),
        .c_q        (c_flag)
    );

    a_r12_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (path_out == '0 && !c_flag));

endmodule

// File: tb/dock_move_ctrl_test.sv
`timescale 1ns/1ps
module dock_move_ctrl_test;
    localparam int PW = 13;
    localparam int WW = 38;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic mv_valid = 0, mv_repeat = 0, mv_immune = 0, mv_count = 0;
    logic mv_tok_in = 0, mv_data_in = 0, mv_keep_c = 0;
    logic [1:0] mv_path_mode = 2'b00;
    logic [PW-1:0] mv_imm = '0;
    logic pred_ok = 0, succ_empty = 0, pkt_valid = 0, pkt_signal = 0, torp_pend = 0;
    logic [WW-1:0] dpred_word = '0;
    logic fire, pkt_take, lc_dec, lc_clr, torp_take, retire, c_flag;
    logic [PW-1:0] path_out;

    dock_move_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mv_valid(mv_valid), .mv_repeat(mv_repeat),
        .mv_immune(mv_immune), .mv_count(mv_count), .mv_tok_in(mv_tok_in),
        .mv_data_in(mv_data_in), .mv_keep_c(mv_keep_c), .mv_path_mode(mv_path_mode),
        .mv_imm(mv_imm), .pred_ok(pred_ok), .succ_empty(succ_empty),
        .pkt_valid(pkt_valid), .pkt_signal(pkt_signal), .dpred_word(dpred_word),
        .torp_pend(torp_pend), .fire(fire), .pkt_take(pkt_take), .lc_dec(lc_dec),
        .lc_clr(lc_clr), .torp_take(torp_take), .retire(retire),
        .path_out(path_out), .c_flag(c_flag)
    );

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R12";
    int cyc = 0;

    // behavioural reference: 0 idle, 1 waiting on a move, 2 between repeats
    int st_m = 0;
    logic [PW-1:0] path_m = '0;
    logic c_m = 1'b0;
    int lc_m = 0;
    bit done_evt = 0;
    bit auto_pred = 0;
    int fire_seen = 0;

    // {fire, take, dec, clr, torp, retire}
    function automatic logic [5:0] expect_now();
        logic [5:0] r = '0;
        bit wants_pkt = (mv_tok_in || mv_data_in);
        if (st_m == 1) begin
            if (!pred_ok) r[0] = 1;
            else if (torp_pend && !mv_immune) begin r[2] = 1; r[1] = 1; r[0] = 1; end
            else if (succ_empty && (!wants_pkt || pkt_valid)) begin
                r[5] = 1; r[4] = wants_pkt; r[3] = mv_count; r[0] = !mv_repeat;
            end
        end
        return r;
    endfunction

    task automatic chk(string nm, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, nm, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        logic [5:0] r;
        cyc++;
        if (!rst_n) begin
            st_m = 0; path_m = '0; c_m = 0; done_evt = 0;
        end else begin
            r = expect_now();
            done_evt = r[0];
            if (r[5]) begin
                if (mv_path_mode == 2'b01) path_m = mv_imm;
                else if (mv_path_mode == 2'b10) path_m = {1'b0, dpred_word[37:26]};
            end
            if (r[4] && !mv_keep_c) c_m = pkt_signal;
            if (r[3]) lc_m--;
            if (r[2]) lc_m = 0;
            case (st_m)
                0: st_m = mv_valid ? 1 : 0;
                1: st_m = r[0] ? 0 : (r[5] ? 2 : 1);
                default: st_m = 1;
            endcase
        end
        if (cyc > 20000) begin
            mismatched++;
            $display("FAIL %s watchdog: actual %0d cycles expected below 20000", cur_req, cyc);
            finish_run();
        end
    end

    always @(negedge clk) begin
        logic [5:0] e;
        e = expect_now();
        chk("fire", fire, e[5]);
        chk("pkt_take", pkt_take, e[4]);
        chk("lc_dec", lc_dec, e[3]);
        chk("lc_clr", lc_clr, e[2]);
        chk("torp_take", torp_take, e[1]);
        chk("retire", retire, e[0]);
        chk("path_out", path_out, path_m);
        chk("c_flag", c_flag, c_m);
        if (fire) fire_seen++;
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            if (auto_pred) pred_ok = (lc_m != 0);
        end
    endtask

    task automatic issue(bit rpt, bit imm_b, bit cnt, bit ti, bit di, bit keep,
                         logic [1:0] mode, logic [PW-1:0] iv);
        mv_repeat = rpt; mv_immune = imm_b; mv_count = cnt; mv_tok_in = ti;
        mv_data_in = di; mv_keep_c = keep; mv_path_mode = mode; mv_imm = iv;
        mv_valid = 1;
    endtask

    task automatic await_done();
        do step(1); while (!done_evt);
        mv_valid = 0;
        step(1);
    endtask

    initial begin
        // R12: reset state
        step(3);
        rst_n = 1;
        step(2);

        // R13 / R8: plain move loading immediate path
        cur_req = "R8";
        pred_ok = 1; succ_empty = 1;
        issue(0, 0, 0, 0, 0, 0, 2'b01, 13'h1ABC);
        await_done();
        chk("R13 path after single move", path_out, 13'h1ABC);

        // R1: wait until successors are empty
        cur_req = "R1";
        succ_empty = 0;
        issue(0, 0, 0, 0, 0, 0, 2'b01, 13'h0123);
        step(4);
        succ_empty = 1;
        await_done();

        // R11 / R7 / R9: wait for data packet, take its signal bit, dispatch path
        cur_req = "R11";
        dpred_word = 38'h2A_5C00_0000;
        issue(0, 0, 0, 0, 1, 0, 2'b10, 13'h0);
        step(3);
        cur_req = "R9";
        pkt_valid = 1; pkt_signal = 1;
        await_done();
        pkt_valid = 0;
        chk("R7 c_flag from packet", c_flag, 1'b1);

        // R7: keep option leaves C untouched
        cur_req = "R7";
        pkt_valid = 1; pkt_signal = 0;
        issue(0, 0, 0, 1, 0, 1, 2'b00, 13'h0);
        await_done();
        pkt_valid = 0;
        chk("R7 c_flag kept", c_flag, 1'b1);

        // R2: false predicate retires at once, nothing loaded
        cur_req = "R2";
        pred_ok = 0;
        issue(0, 0, 1, 0, 0, 0, 2'b01, 13'h0777);
        await_done();
        pred_ok = 1;

        // R4: counting repeat stops when predicate (counter nonzero) fails
        cur_req = "R4";
        lc_m = 4; auto_pred = 1;
        fire_seen = 0;
        issue(1, 0, 1, 0, 0, 0, 2'b01, 13'h0456);
        await_done();
        auto_pred = 0; pred_ok = 1;
        chk("R4 firings", fire_seen, 4);
        chk("R4 counter", lc_m, 0);

        // R3: standing move, never counts, ends on predicate
        cur_req = "R3";
        lc_m = 7; fire_seen = 0;
        issue(1, 0, 0, 0, 0, 0, 2'b00, 13'h0);
        step(8);
        pred_ok = 0;
        await_done();
        pred_ok = 1;
        chk("R3 counter untouched", lc_m, 7);
        chk("R3 fire spacing", fire_seen >= 3, 1);

        // R5: torpedo kills a waiting non-immune move
        cur_req = "R5";
        succ_empty = 0;
        issue(0, 0, 1, 0, 0, 0, 2'b01, 13'h0999);
        step(2);
        torp_pend = 1;
        await_done();
        torp_pend = 0;
        chk("R5 counter cleared", lc_m, 0);

        // R5: strike wins over a ready firing
        succ_empty = 1; lc_m = 3;
        torp_pend = 1;
        issue(0, 0, 1, 0, 0, 0, 2'b01, 13'h0AAA);
        await_done();
        torp_pend = 0;

        // R6: immune move ignores the torpedo
        cur_req = "R6";
        succ_empty = 0; torp_pend = 1;
        issue(0, 1, 0, 0, 0, 0, 2'b01, 13'h0BBB);
        step(3);
        succ_empty = 1;
        await_done();
        torp_pend = 0;

        // R10: keep and reserved path modes
        cur_req = "R10";
        dpred_word = 38'h3F_FC00_0000;
        issue(0, 0, 0, 0, 0, 0, 2'b00, 13'h1111);
        await_done();
        issue(0, 0, 0, 0, 0, 0, 2'b11, 13'h1222);
        await_done();
        chk("R10 path kept", path_out, 13'h0BBB);

        // R9: second dispatch value
        cur_req = "R9";
        issue(0, 0, 0, 0, 0, 0, 2'b10, 13'h0);
        await_done();
        chk("R9 dispatch field", path_out, 13'h0FFF);

        step(3);
        finish_run();
    end
endmodule